// File: doc/BRIEF.md
# Two-Wire Up/Down Wiper Controller

This block is the digital half of a 32-position volatile potentiometer. A host drives two asynchronous lines: an active-low select and a combined direction/step line. When select goes low, the block records the level of the step line at that moment as the travel direction. It keeps that direction until select rises again. While selected, every rising edge of the step line moves a 5-bit wiper position one place in that direction. The position stops at either end and never wraps. The position is decoded into a one-hot enable for the tap switches of the resistor string.

Both lines pass through synchronizers on a fast system clock, and all edges are found on the synchronized copies. A monitor measures each high and low phase of the step line while the block is selected. It raises a sticky flag if a phase is shorter than the legal minimum. A build option makes the block discard a step whose rising edge ends a phase that is too short. Reset loads a configurable power-up position, mid-scale by default, because the storage does not survive power loss.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset the wiper position is RESET_POS (16 by default). `tap_sel` has only bit 16 set, `standby` is 1, `dir_up` is 0 and `timing_err` is 0.
- R2: On the cycle where the synchronized select is seen going from high to low, the synchronized step-line level is stored as the direction (1 = up, 0 = down) and shown on `dir_up`. The direction is held for the whole selected period.
- R3: While selected, each rising edge of the step line moves the position by exactly one in the stored direction. The new value appears on the third clock edge after the input changes. Falling edges leave the position unchanged.
- R4: An up step at position 31 leaves 31, and a down step at position 0 leaves 0. There is no wraparound.
- R5: While select is high, `standby` is 1, the step line has no effect and the position is held.
- R6: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper_pos`. Bit 0 is the low-terminal end and bit 31 is the high-terminal end.
- R7: When the select falling edge and a step-line rising edge are seen in the same clock, only the direction is stored. The position does not move.
- R8: While selected, if a step-line high or low phase lasts fewer than MIN_PHASE_NS/CLK_PERIOD_NS clocks (15 by default), `timing_err` is set. It then stays at 1 until reset.
- R9: With DROP_GLITCH=1, a rising edge that ends a too-short low phase produces no step. With DROP_GLITCH=0, the same edge steps normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample both lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_in | input | 1 | Asynchronous active-low select |
| updn_in | input | 1 | Asynchronous direction level and step clock |
| wiper_pos | output | 5 | Current wiper position, 0 to 31 |
| tap_sel | output | 32 | One-hot tap switch enables |
| standby | output | 1 | High while the block is deselected |
| dir_up | output | 1 | Stored direction, 1 = up |
| timing_err | output | 1 | Sticky step-line phase-width violation |

## Verification
The checker watches these properties on every cycle:
- the one-hot decode and its match with the position;
- that the position moves by at most one place and never jumps between the two ends;
- that the position is frozen while deselected and changes only after a selected cycle;
- that the direction stays steady inside a selected period;
- that the error flag never clears once set.

Some behaviours only the directed scenarios can show:
- which direction gets stored;
- that a falling edge causes no step;
- the exact saturation values;
- the same-cycle select/step collision;
- the difference between counting and dropping a short pulse, seen by running two builds side by side on identical stimulus.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } wiper_dir_e;
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wiper_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wiper_phase_mon.sv
module wiper_phase_mon #(
   parameter int MIN_CLKS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic active,
   output logic rise,
   output logic short_edge,
   output logic err
);
   localparam int CW = $clog2(MIN_CLKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MIN_CLKS);

   logic          lvl_q;
   logic [CW-1:0] run_len;
   logic          any_edge;

   assign any_edge   = lvl ^ lvl_q;
   assign rise       = lvl & ~lvl_q;
   assign short_edge = any_edge && (run_len < LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= 1'b0;
         run_len <= LIMIT;
         err     <= 1'b0;
      end else begin
         lvl_q <= lvl;
         if (any_edge)             run_len <= CW'(1);
         else if (run_len < LIMIT) run_len <= run_len + CW'(1);
         if (active && short_edge) err <= 1'b1;
      end
   end
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
   import wiper_pkg::*;
#(
   parameter int TAPS        = 32,
   parameter int POS_W       = 5,
   parameter int RESET_POS   = 16,
   parameter bit DROP_GLITCH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_s,
   input  logic             ud_s,
   input  logic             rise,
   input  logic             short_edge,
   output logic [POS_W-1:0] pos,
   output wiper_dir_e       dir
);
   localparam logic [POS_W-1:0] TOP_POS = POS_W'(TAPS - 1);
   localparam logic [POS_W-1:0] RST_POS = POS_W'(RESET_POS);

   logic sel_q;
   logic sel_fall;
   logic accept;
   logic step;

   generate
      if (DROP_GLITCH) begin : g_drop
         assign accept = rise & ~short_edge;
      end else begin : g_keep
         assign accept = rise;
      end
   endgenerate

   assign sel_fall = sel_q & ~sel_s;
   assign step     = ~sel_s & ~sel_fall & accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b1;
         dir   <= DIR_DOWN;
         pos   <= RST_POS;
      end else begin
         sel_q <= sel_s;
         if (sel_fall) begin
            dir <= ud_s ? DIR_UP : DIR_DOWN;
         end else if (step) begin
            if (dir == DIR_UP) begin
               if (pos != TOP_POS) pos <= pos + POS_W'(1);
            end else begin
               if (pos != '0) pos <= pos - POS_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
   parameter int TAPS  = 32,
   parameter int POS_W = 5
) (
   input  logic [POS_W-1:0] pos,
   output logic [TAPS-1:0]  tap_sel
);
   generate
      for (genvar i = 0; i < TAPS; i++) begin : g_tap
         assign tap_sel[i] = (pos == POS_W'(i));
      end
   endgenerate
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
   import wiper_pkg::*;
#(
   parameter int TAPS          = 32,
   parameter int RESET_POS     = 16,
   parameter int CLK_PERIOD_NS = 20,
   parameter int MIN_PHASE_NS  = 300,
   parameter bit DROP_GLITCH   = 1'b0,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_n_in,
   input  logic                    updn_in,
   output logic [$clog2(TAPS)-1:0] wiper_pos,
   output logic [TAPS-1:0]         tap_sel,
   output logic                    standby,
   output logic                    dir_up,
   output logic                    timing_err
);
   localparam int POS_W          = $clog2(TAPS);
   localparam int MIN_PHASE_CLKS = MIN_PHASE_NS / CLK_PERIOD_NS;

   generate
      if (TAPS < 2) begin : g_bad_taps
         $error("TAPS must be at least 2");
      end
      if (RESET_POS < 0 || RESET_POS >= TAPS) begin : g_bad_rst
         $error("RESET_POS must lie inside the tap range");
      end
      if (MIN_PHASE_CLKS < 2) begin : g_bad_phase
         $error("minimum phase must span at least two clocks");
      end
   endgenerate

   logic       sel_s;
   logic       ud_s;
   logic       ud_rise;
   logic       ud_short;
   wiper_dir_e dir_q;

   wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
      .clk(clk), .rst_n(rst_n), .d(sel_n_in), .q(sel_s)
   );

   wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ud_sync (
      .clk(clk), .rst_n(rst_n), .d(updn_in), .q(ud_s)
   );

   wiper_phase_mon #(.MIN_CLKS(MIN_PHASE_CLKS)) u_phase (
      .clk(clk), .rst_n(rst_n), .lvl(ud_s), .active(~sel_s),
      .rise(ud_rise), .short_edge(ud_short), .err(timing_err)
   );

   wiper_counter #(
      .TAPS(TAPS), .POS_W(POS_W), .RESET_POS(RESET_POS), .DROP_GLITCH(DROP_GLITCH)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .ud_s(ud_s),
      .rise(ud_rise), .short_edge(ud_short), .pos(wiper_pos), .dir(dir_q)
   );

   wiper_tap_decode #(.TAPS(TAPS), .POS_W(POS_W)) u_decode (
      .pos(wiper_pos), .tap_sel(tap_sel)
   );

   assign standby = sel_s;
   assign dir_up  = (dir_q == DIR_UP);
endmodule

// File: rtl/wiper_step_chk.sv
module wiper_step_chk #(
   parameter int TAPS  = 32,
   parameter int POS_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             standby,
   input logic             dir_up,
   input logic [POS_W-1:0] wiper_pos,
   input logic [TAPS-1:0]  tap_sel,
   input logic             timing_err
);
   // R6
   onehot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

   // R4
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)}) ||
      ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} + 1'b1) ||
      ({1'b0, wiper_pos} + 1'b1 == {1'b0, $past(wiper_pos)}));

   // R5
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(standby) |-> (wiper_pos == $past(wiper_pos)));

   // R3
   move_when_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper_pos != $past(wiper_pos)) |-> !$past(standby));

   // R2
   dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby && !$past(standby) && !$past(standby, 2)) |-> $stable(dir_up));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(timing_err) |-> timing_err);
endmodule

bind wiper_step_ctrl wiper_step_chk #(.TAPS(TAPS), .POS_W(POS_W)) u_wiper_chk (
   .clk(clk), .rst_n(rst_n), .standby(standby), .dir_up(dir_up),
   .wiper_pos(wiper_pos), .tap_sel(tap_sel), .timing_err(timing_err)
);

// File: tb/wiper_step_ctrl_bench.sv
module wiper_step_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        updn = 1'b0;
   logic [4:0]  pos_a, pos_b;
   logic [31:0] tap_a, tap_b;
   logic        stby_a, stby_b, dir_a, dir_b, err_a, err_b;

   int n_chk = 0;
   int n_fail = 0;
   int exp_a = 16;
   int exp_b = 16;
   bit exp_up = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wiper_step_ctrl u_wiper_step_ctrl (
      .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n), .updn_in(updn),
      .wiper_pos(pos_a), .tap_sel(tap_a), .standby(stby_a),
      .dir_up(dir_a), .timing_err(err_a)
   );

   wiper_step_ctrl #(.DROP_GLITCH(1'b1)) u_wiper_step_ctrl_drop (
      .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n), .updn_in(updn),
      .wiper_pos(pos_b), .tap_sel(tap_b), .standby(stby_b),
      .dir_up(dir_b), .timing_err(err_b)
   );

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sat(input int p, input bit up);
      if (up) return (p >= 31) ? 31 : p + 1;
      return (p <= 0) ? 0 : p - 1;
   endfunction

   // one clean step: long low phase, then rise, then long high phase
   task automatic pulse();
      updn = 1'b0;
      idle(20);
      updn = 1'b1;
      if (sel_n == 1'b0) begin
         exp_a = sat(exp_a, exp_up);
         exp_b = sat(exp_b, exp_up);
      end
      idle(20);
   endtask

   task automatic check_pos(input string req);
      check(req, "pos_a", pos_a, exp_a);
      check(req, "pos_b", pos_b, exp_b);
   endtask

   task automatic select_dir(input bit up);
      sel_n = 1'b1;
      idle(20);
      updn = up;
      idle(20);
      sel_n = 1'b0;
      exp_up = up;
      idle(20);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle(5);
      rst_n = 1'b1;
      idle(5);
      check("R1", "pos", pos_a, 16);
      check("R1", "standby", stby_a, 1);
      check("R1", "dir_up", dir_a, 0);
      check("R1", "timing_err", err_a, 0);
      check("R6", "tap_sel", tap_a, 32'h0001_0000);
   endtask

   task automatic t_idle_ignore();
      for (int i = 0; i < 5; i++) pulse();
      check_pos("R5");
      check("R5", "standby", stby_a, 1);
   endtask

   task automatic t_up_steps();
      select_dir(1'b1);
      check("R2", "dir_up", dir_a, 1);
      check("R5", "standby low", stby_a, 0);
      for (int i = 0; i < 3; i++) pulse();
      check_pos("R3");
      check("R6", "tap_sel", tap_a, 32'h1 << 19);
   endtask

   task automatic t_falling_only();
      updn = 1'b0;
      idle(20);
      check("R3", "falling edge", pos_a, 19);
   endtask

   task automatic t_down_steps();
      select_dir(1'b0);
      check("R2", "dir_up", dir_a, 0);
      for (int i = 0; i < 5; i++) pulse();
      check("R3", "down to 14", pos_a, 14);
      check_pos("R3");
   endtask

   task automatic t_saturate();
      for (int i = 0; i < 20; i++) pulse();
      check("R4", "floor", pos_a, 0);
      check("R6", "tap_sel floor", tap_a, 32'h1);
      select_dir(1'b1);
      for (int i = 0; i < 40; i++) pulse();
      check("R4", "ceiling", pos_a, 31);
      check("R6", "tap_sel ceiling", tap_a, 32'h8000_0000);
      select_dir(1'b0);
      for (int i = 0; i < 3; i++) pulse();
      check("R4", "back down", pos_a, 28);
   endtask

   task automatic t_simultaneous();
      sel_n = 1'b1;
      idle(20);
      updn = 1'b0;
      idle(20);
      sel_n = 1'b0;
      updn = 1'b1;
      exp_up = 1'b1;
      idle(20);
      check("R7", "no step", pos_a, 28);
      check("R7", "dir_up", dir_a, 1);
      pulse();
      check("R7", "next step up", pos_a, 29);
      check_pos("R7");
   endtask

   task automatic t_glitch();
      updn = 1'b0;
      idle(4);
      updn = 1'b1;
      exp_a = sat(exp_a, 1'b1);
      idle(20);
      check("R9", "kept short step", pos_a, 30);
      check("R9", "dropped short step", pos_b, 29);
      check("R8", "err_a", err_a, 1);
      check("R8", "err_b", err_b, 1);
      exp_b = 29;
      pulse();
      check_pos("R9");
      check("R8", "err_a sticky", err_a, 1);
   endtask

   task automatic t_reset_clears();
      rst_n = 1'b0;
      idle(5);
      rst_n = 1'b1;
      idle(5);
      check("R8", "err cleared", err_a, 0);
      check("R1", "pos after reset", pos_b, 16);
   endtask

   initial begin
      idle(2);
      t_reset();
      t_idle_ignore();
      t_up_steps();
      t_falling_only();
      t_down_steps();
      t_saturate();
      t_simultaneous();
      t_glitch();
      t_reset_clears();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule